// File: doc/BRIEF.md
# Bus-Snooping Output Latch

This block sits beside a processor's parallel bus and drives an 8-bit output register that feeds LEDs or appliance switches. It watches the address bus, the data bus and the active-low write and space strobes, and it recognises a write aimed at its own device address. On a match it takes the data byte from the bus while the cycle is valid. When the strobes release, it commits that byte to the output register and pulses a one-clock write strobe.

The device address is the parameter `DEV_ADDR`. The parameter `MAP_MODE` selects how the block decodes the bus:

- `MAP_PORT` (port space): only the low 8 address bits are compared, so any port number from 00h to FFh can be assigned. The default port number is 07h. The write is qualified by the I/O request strobe together with the write strobe.
- `MAP_MEMORY` (memory space): all 16 address bits are compared. The write is qualified by the memory request strobe together with the write strobe.

All bus inputs are registered once on `clk` before decoding. A small state machine then tracks the write:

- States: `ST_IDLE`, `ST_CAPTURE` and `ST_COMMIT`.
- Transitions:
  - idle→capture when a qualified matching write is seen.
  - capture→capture while it persists.
  - capture→commit when it ends.
  - commit→capture if a new matching write is already present.
  - commit→idle otherwise.

Top module: `out_latch_top`

## Requirements
- R1: While `rst_n` is low and after its release, `out_q` reads 00h and `wr_pulse` reads 0 until a qualified write completes.
- R2: In port mode only `bus_addr[7:0]` is compared with the low byte of `DEV_ADDR` (default 07h). `bus_addr[15:8]` has no effect on selection.
- R3: In port mode a write is recognised only while `iorq_n` and `wr_n` are both 0. Cycles that use `mreq_n` instead leave `out_q` unchanged and give no pulse.
- R4: In memory mode all 16 bits of `bus_addr` must equal `DEV_ADDR`, with `mreq_n` and `wr_n` both 0. Cycles that use `iorq_n` leave `out_q` unchanged and give no pulse.
- R5: Take the first rising clock edge at which the released strobes are registered. `out_q` takes its new value one edge after that. The cycle before that edge still shows the old value.
- R6: The value committed is the byte on `bus_data` at the last rising edge at which the qualified write was still registered as active. Earlier values from the same cycle are overwritten.
- R7: `wr_pulse` is high for exactly one clock per completed matching write. That is the same cycle in which `out_q` first shows the new byte, and it is never high in two consecutive cycles.
- R8: Read cycles (`wr_n` high), writes to any non-matching address and idle bus cycles leave `out_q` holding its last value and `wr_pulse` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 8 | Processor data bus |
| iorq_n | input | 1 | Active-low I/O space request |
| mreq_n | input | 1 | Active-low memory space request |
| wr_n | input | 1 | Active-low write strobe |
| out_q | output | 8 | Latched output byte |
| wr_pulse | output | 1 | One-clock pulse on each register update |

## Verification
A state machine stuck in capture would freeze `out_q` and suppress `wr_pulse` forever. One that skips commit, or lingers in it, shows up as a missing or doubled pulse two edges after a strobe release. A wrong decode or a wrong strobe qualifier shows up as an unexpected `out_q` change or pulse. That change appears exactly two cycles after the offending access ends, so every access in the sweep is judged within three cycles of its release. A holding register that samples at the wrong time commits the earlier, deliberately different data byte of the same cycle instead of the final one.

// File: rtl/out_latch_pkg.sv
package out_latch_pkg;
    typedef enum logic {
        MAP_PORT   = 1'b0,
        MAP_MEMORY = 1'b1
    } map_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_COMMIT  = 2'd2
    } latch_state_e;
endpackage

// File: rtl/out_latch_sampler.sv
module out_latch_sampler #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              wr_n,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_data,
    output logic              s_iorq_n,
    output logic              s_mreq_n,
    output logic              s_wr_n
);
    // single register stage between the asynchronous bus and the decoder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_addr   <= '0;
            s_data   <= '0;
            s_iorq_n <= 1'b1;
            s_mreq_n <= 1'b1;
            s_wr_n   <= 1'b1;
        end else begin
            s_addr   <= bus_addr;
            s_data   <= bus_data;
            s_iorq_n <= iorq_n;
            s_mreq_n <= mreq_n;
            s_wr_n   <= wr_n;
        end
    end
endmodule

// File: rtl/out_latch_decode.sv
module out_latch_decode
    import out_latch_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter int               PORT_W   = 8,
    parameter map_mode_e        MAP_MODE = MAP_PORT,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 16'h0007
) (
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_iorq_n,
    input  logic              s_mreq_n,
    input  logic              s_wr_n,
    output logic              hit
);
    generate
        if (MAP_MODE == MAP_PORT) begin : g_port
            // upper address byte plays no part in port-space selection (R2)
            logic unused_hi;
            logic unused_mreq;
            assign unused_hi   = ^s_addr[ADDR_W-1:PORT_W];
            assign unused_mreq = s_mreq_n;
            assign hit = !s_iorq_n && !s_wr_n &&
                         (s_addr[PORT_W-1:0] == DEV_ADDR[PORT_W-1:0]);
        end else begin : g_mem
            logic unused_iorq;
            assign unused_iorq = s_iorq_n;
            assign hit = !s_mreq_n && !s_wr_n && (s_addr == DEV_ADDR);
        end
    endgenerate
endmodule

// File: rtl/out_latch_fsm.sv
module out_latch_fsm
    import out_latch_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] s_data,
    output logic [DATA_W-1:0] out_q,
    output logic              wr_pulse
);
    latch_state_e state, state_nx;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = hit ? ST_CAPTURE : ST_IDLE;
            ST_CAPTURE: state_nx = hit ? ST_CAPTURE : ST_COMMIT;
            ST_COMMIT:  state_nx = hit ? ST_CAPTURE : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs: holding byte follows the bus while the cycle is valid (R6),
    // output register loads on the way into commit (R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            out_q  <= '0;
        end else begin
            if (hit) hold_q <= s_data;
            if (state == ST_CAPTURE && !hit) out_q <= hold_q;
        end
    end

    assign wr_pulse = (state == ST_COMMIT);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    assert_change_has_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> wr_pulse);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0 && !wr_pulse));
endmodule

// File: rtl/out_latch_top.sv
module out_latch_top
    import out_latch_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter int                PORT_W   = 8,
    parameter map_mode_e         MAP_MODE = MAP_PORT,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 16'h0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              wr_n,
    output logic [DATA_W-1:0] out_q,
    output logic              wr_pulse
);
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              s_iorq_n, s_mreq_n, s_wr_n;
    logic              hit;

    out_latch_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n),
        .s_addr(s_addr), .s_data(s_data),
        .s_iorq_n(s_iorq_n), .s_mreq_n(s_mreq_n), .s_wr_n(s_wr_n)
    );

    out_latch_decode #(.ADDR_W(ADDR_W), .PORT_W(PORT_W),
                       .MAP_MODE(MAP_MODE), .DEV_ADDR(DEV_ADDR)) u_dec (
        .s_addr(s_addr), .s_iorq_n(s_iorq_n), .s_mreq_n(s_mreq_n),
        .s_wr_n(s_wr_n), .hit(hit)
    );

    out_latch_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .s_data(s_data),
        .out_q(out_q), .wr_pulse(wr_pulse)
    );

    // a pulse follows a bus cycle whose write qualification had ended
    assert_pulse_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(wr_n | (iorq_n & mreq_n), 2));

    // a read cycle never marks the decoder as hit
    assert_read_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_n) |-> !hit);
endmodule

// File: tb/out_latch_tb_top.sv
`timescale 1ns/1ps
module out_latch_tb_top;
    import out_latch_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        iorq_n = 1'b1, mreq_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  q_p, q_m;
    logic        p_p, p_m;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] exp_p = 8'h00, exp_m = 8'h00;

    localparam logic [15:0] MEM_ADDR = 16'h8007;

    always #2.5 clk = ~clk;

    out_latch_top #(.MAP_MODE(MAP_PORT), .DEV_ADDR(16'h0007)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n),
        .out_q(q_p), .wr_pulse(p_p));

    out_latch_top #(.MAP_MODE(MAP_MEMORY), .DEV_ADDR(MEM_ADDR)) dut_m (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n),
        .out_q(q_m), .wr_pulse(p_m));

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one bus cycle: three active clocks, data only final in the last one
    task automatic cycle(bit use_mem, bit is_wr, logic [15:0] a, logic [7:0] d, string tag);
        bit hp, hm;
        hp = !use_mem && is_wr && (a[7:0] == 8'h07);
        hm = use_mem && is_wr && (a == MEM_ADDR);
        @(negedge clk);
        bus_addr = a; bus_data = ~d;
        iorq_n = use_mem; mreq_n = !use_mem; wr_n = !is_wr;
        @(negedge clk);
        @(negedge clk);
        bus_data = d;
        @(negedge clk);
        iorq_n = 1'b1; mreq_n = 1'b1; wr_n = 1'b1; bus_data = 8'h00;
        @(negedge clk);
        // R5: one cycle after release nothing has changed yet
        chk({tag, " R5 port early"}, q_p, exp_p);
        chk({tag, " R5 mem early"},  q_m, exp_m);
        chk({tag, " R7 port early pulse"}, {7'd0, p_p}, 8'd0);
        chk({tag, " R7 mem early pulse"},  {7'd0, p_m}, 8'd0);
        if (hp) exp_p = d;
        if (hm) exp_m = d;
        @(negedge clk);
        // R6: final data byte committed; R2/R3/R4/R8 decode decided it
        chk({tag, " R6 port value"}, q_p, exp_p);
        chk({tag, " R6 mem value"},  q_m, exp_m);
        chk({tag, " R7 port pulse"}, {7'd0, p_p}, {7'd0, hp});
        chk({tag, " R7 mem pulse"},  {7'd0, p_m}, {7'd0, hm});
        @(negedge clk);
        chk({tag, " R7 port pulse end"}, {7'd0, p_p}, 8'd0);
        chk({tag, " R7 mem pulse end"},  {7'd0, p_m}, 8'd0);
        chk({tag, " R8 port hold"}, q_p, exp_p);
        chk({tag, " R8 mem hold"},  q_m, exp_m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 port reset", q_p, 8'h00);
        chk("R1 mem reset",  q_m, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 port after reset", {q_p[7:1], p_p}, 8'h00);
        chk("R1 mem after reset",  {q_m[7:1], p_m}, 8'h00);
        // port-space sweep of every low address byte, upper byte scrambled (R2, R3)
        for (int a = 0; a < 256; a++)
            cycle(1'b0, 1'b1, {8'(a) ^ 8'h5A, 8'(a)}, 8'(a) ^ 8'hC3, "R2 sweep");
        // memory-space sweep with the matching high byte (R4)
        for (int a = 0; a < 256; a++)
            cycle(1'b1, 1'b1, {8'h80, 8'(a)}, 8'(a) + 8'h11, "R4 low sweep");
        // memory-space sweep of the high byte with the matching low byte (R4)
        for (int a = 0; a < 256; a++)
            cycle(1'b1, 1'b1, {8'(a), 8'h07}, 8'(a) ^ 8'h96, "R4 high sweep");
        // port write through memory strobe at 0007 and memory write through I/O strobe (R3, R4)
        cycle(1'b1, 1'b1, 16'h0007, 8'hA5, "R3 wrong space");
        cycle(1'b0, 1'b1, MEM_ADDR, 8'h3C, "R4 io at mem addr");
        // reads at both device addresses (R8)
        cycle(1'b0, 1'b0, 16'h0007, 8'hFF, "R8 io read");
        cycle(1'b1, 1'b0, MEM_ADDR, 8'hEE, "R8 mem read");
        // repeated writes with distinct data (R6)
        for (int k = 0; k < 8; k++) begin
            cycle(1'b0, 1'b1, {8'(k), 8'h07}, 8'(1 << k), "R6 walk io");
            cycle(1'b1, 1'b1, MEM_ADDR, ~8'(1 << k), "R6 walk mem");
        end
        // idle bus (R8)
        repeat (10) @(negedge clk);
        chk("R8 idle port", q_p, exp_p);
        chk("R8 idle mem",  q_m, exp_m);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule